// File: doc/BRIEF.md
# Transmit Phase-Alignment Sequencer

This controller steps a serial transmitter, whose transmit elastic buffer is bypassed, through its phase-alignment procedure. It starts after a line-rate change has completed, or after any event that makes the transmit clock phase unknown. Such events are a transceiver reset, PLL power-up, a clock-source switch or a rate reprogramming, and a single restart-request input reports all of them. A rate-change sequence first pulses the output clock-divider reset for an exact number of cycles. It then raises the phase-align enable and holds it. After a settling interval it drives the set-phase strobe, fires a transmitter reset and waits for the reset-done input. A restart sequence runs the same steps without the divider reset.

A mode input selects PCI Express behaviour. In that mode a rate change counts as complete only when a PHY-status pulse follows a rate-done pulse. The transceiver PHY-status is passed to the user side unchanged while nothing is in progress. During a rate change and its alignment the PHY-status is masked, and one user PHY-status pulse is issued when alignment ends. In the other mode a single rate-done pulse completes the rate change, and a sync-done level reports finished alignment instead. Requests that arrive while a sequence runs are held and serviced afterwards.

Top module: `txpa_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle within one clock. All four control strobes and both status outputs are low, and any held request or half-seen handshake is discarded.
- R2: With pcie_mode low, a rate_done_i pulse sampled while idle starts a rate sequence. clkdiv_rst_o is high from the following cycle.
- R3: clkdiv_rst_o stays high for exactly DIVRST_CYC consecutive cycles (default 16).
- R4: align_en_o rises in the cycle after clkdiv_rst_o falls and stays high through the rest of the sequence. set_phase_o rises only after align_en_o has been high for ALIGN_WAIT_CYC cycles (default 32, never below 32).
- R5: set_phase_o is high for SETPH_CYC cycles. tx_rst_o is then high for TXRST_CYC cycles, and only one of these two strobes and clkdiv_rst_o is high at a time. After tx_rst_o the block waits for reset_done_i. In the cycle after reset_done_i is sampled high, every strobe is low.
- R6: With pcie_mode high, completion needs a phystatus_i pulse in a cycle strictly later than a rate_done_i pulse. A phystatus_i pulse with no earlier rate_done_i, or in the same cycle as it, starts nothing.
- R7: With pcie_mode high, user_phystatus_o equals phystatus_i in the same cycle while the block is idle, has no held request and has not seen a rate_done_i waiting for its PHY status. Otherwise phystatus_i is masked. A finished rate sequence gives exactly one one-cycle user_phystatus_o pulse, in the cycle after reset_done_i is sampled. With pcie_mode low, user_phystatus_o is always low.
- R8: With pcie_mode low, sync_done_o goes low when any sequence starts and goes high in the cycle after the sequence finishes. With pcie_mode high it is always low.
- R9: A restart_i pulse sampled while idle starts a sequence at the alignment step: align_en_o is high in the next cycle and clkdiv_rst_o stays low. Its end gives no user_phystatus_o pulse.
- R10: A rate completion or restart_i sampled while a sequence runs, including the cycle in which reset_done_i ends it, is held. It starts a new sequence after one idle cycle. A rate request wins over a restart, and a restart that is held or sampled together with a rate request is absorbed into the rate sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous active-high reset |
| pcie_mode | input | 1 | 1 selects PCI Express completion and status behaviour |
| rate_done_i | input | 1 | Rate-change done pulse from the transceiver |
| phystatus_i | input | 1 | PHY-status pulse from the transceiver |
| restart_i | input | 1 | Request to re-run alignment after reset, PLL power-up or clock change |
| reset_done_i | input | 1 | Transmitter reset-done level |
| clkdiv_rst_o | output | 1 | Output clock-divider reset |
| align_en_o | output | 1 | Phase-align enable |
| set_phase_o | output | 1 | Set-phase strobe |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| user_phystatus_o | output | 1 | Gated PHY status for the user side (PCI Express mode) |
| sync_done_o | output | 1 | Alignment-complete flag (non-PCI-Express mode) |

## Verification
Two pairs of functions can fall in one cycle. In the first, a new rate-done pulse arrives in the very cycle that reset-done ends the running sequence. The bench holds reset-done under its own control and raises it together with rate-done. It expects the request to be held, one idle cycle to pass, and a second divider reset to follow. In the second, a PHY-status pulse coincides with a rate-done pulse, or arrives while a sequence runs. The bench judges that it is masked on the user side and neither completes nor starts anything. A behavioural reference model predicts every output on every cycle for all of these cases.

// File: rtl/txpa_pkg.sv
package txpa_pkg;

   // Sequencer phases in the order they are walked
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_CLKDIV   = 3'd1,
      ST_ALIGN    = 3'd2,
      ST_SETPH    = 3'd3,
      ST_TXRST    = 3'd4,
      ST_WAITDONE = 3'd5
   } txpa_state_e;

   // What kind of event launched the running sequence
   typedef enum logic {
      SEQ_RESTART = 1'b0,
      SEQ_RATE    = 1'b1
   } txpa_kind_e;

   function automatic int unsigned txpa_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/txpa_cplt_det.sv
// Rate-change completion detector: one pulse in legacy mode, a two-stage
// handshake (rate done, then PHY status in a later cycle) in PCI Express mode.
module txpa_cplt_det (
   input  logic clk,
   input  logic rst,
   input  logic pcie_mode,
   input  logic rate_done_i,
   input  logic phystatus_i,
   output logic cplt_o,
   output logic armed_o
);

   logic armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
      end else if (!pcie_mode) begin
         armed_q <= 1'b0;
      end else if (rate_done_i) begin
         armed_q <= 1'b1;
      end else if (phystatus_i) begin
         armed_q <= 1'b0;
      end
   end

   // A status pulse only counts once the rate-done stage was recorded earlier
   assign cplt_o  = pcie_mode ? (armed_q & phystatus_i) : rate_done_i;
   assign armed_o = armed_q;

endmodule

// File: rtl/txpa_req_latch.sv
// Holds requests that arrive while a sequence runs. The hold is dropped
// whenever the sequencer is idle, since the idle cycle services it.
module txpa_req_latch (
   input  logic clk,
   input  logic rst,
   input  logic busy_i,
   input  logic cplt_i,
   input  logic restart_i,
   output logic pend_rate_o,
   output logic pend_restart_o
);

   logic pend_rate_q;
   logic pend_restart_q;

   always_ff @(posedge clk) begin
      if (rst || !busy_i) begin
         pend_rate_q    <= 1'b0;
         pend_restart_q <= 1'b0;
      end else begin
         pend_rate_q    <= pend_rate_q    | cplt_i;
         pend_restart_q <= pend_restart_q | restart_i;
      end
   end

   assign pend_rate_o    = pend_rate_q;
   assign pend_restart_o = pend_restart_q;

endmodule

// File: rtl/txpa_interval_cnt.sv
// Shared down-counter, reloaded on each phase entry, saturating at zero.
module txpa_interval_cnt #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/txpa_stat_gate.sv
// User-side status: masked PHY status with a single release pulse, or a
// sync-done level, depending on mode.
module txpa_stat_gate (
   input  logic clk,
   input  logic rst,
   input  logic pcie_mode,
   input  logic phystatus_i,
   input  logic gate_i,
   input  logic start_i,
   input  logic finish_i,
   input  logic finish_rate_i,
   output logic user_phystatus_o,
   output logic sync_done_o
);

   logic release_q;
   logic synced_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         release_q <= 1'b0;
         synced_q  <= 1'b0;
      end else begin
         release_q <= finish_i & finish_rate_i & pcie_mode;
         if (start_i) begin
            synced_q <= 1'b0;
         end else if (finish_i) begin
            synced_q <= 1'b1;
         end
      end
   end

   assign user_phystatus_o = pcie_mode & (release_q | (phystatus_i & ~gate_i));
   assign sync_done_o      = ~pcie_mode & synced_q;

endmodule

// File: rtl/txpa_seq.sv
module txpa_seq
   import txpa_pkg::*;
#(
   parameter int unsigned DIVRST_CYC     = 16,
   parameter int unsigned ALIGN_WAIT_CYC = 32,
   parameter int unsigned SETPH_CYC      = 8,
   parameter int unsigned TXRST_CYC      = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic pcie_mode,
   input  logic rate_done_i,
   input  logic phystatus_i,
   input  logic restart_i,
   input  logic reset_done_i,
   output logic clkdiv_rst_o,
   output logic align_en_o,
   output logic set_phase_o,
   output logic tx_rst_o,
   output logic user_phystatus_o,
   output logic sync_done_o
);

   localparam int unsigned CNT_MAX = txpa_max2(txpa_max2(DIVRST_CYC, ALIGN_WAIT_CYC),
                                               txpa_max2(SETPH_CYC, TXRST_CYC));
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LD_CLKDIV = CNT_W'(DIVRST_CYC - 1);
   localparam logic [CNT_W-1:0] LD_ALIGN  = CNT_W'(ALIGN_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] LD_SETPH  = CNT_W'(SETPH_CYC - 1);
   localparam logic [CNT_W-1:0] LD_TXRST  = CNT_W'(TXRST_CYC - 1);

   // Elaboration-time parameter checks
   if (DIVRST_CYC < 1) begin : g_bad_divrst
      $error("txpa_seq: DIVRST_CYC must be at least 1");
   end
   if (ALIGN_WAIT_CYC < 32) begin : g_bad_align
      $error("txpa_seq: ALIGN_WAIT_CYC must be at least 32");
   end
   if (SETPH_CYC < 1) begin : g_bad_setph
      $error("txpa_seq: SETPH_CYC must be at least 1");
   end
   if (TXRST_CYC < 1) begin : g_bad_txrst
      $error("txpa_seq: TXRST_CYC must be at least 1");
   end

   txpa_state_e      state_q, state_d;
   txpa_kind_e       kind_q, kind_d;
   logic             cplt, armed;
   logic             pend_rate, pend_restart;
   logic             busy, idle;
   logic             start_rate, start_restart, finish;
   logic             cnt_load, cnt_zero;
   logic [CNT_W-1:0] cnt_val;
   logic             gate;

   assign idle = (state_q == ST_IDLE);
   assign busy = ~idle;

   txpa_cplt_det u_cplt (
      .clk         (clk),
      .rst         (rst),
      .pcie_mode   (pcie_mode),
      .rate_done_i (rate_done_i),
      .phystatus_i (phystatus_i),
      .cplt_o      (cplt),
      .armed_o     (armed)
   );

   txpa_req_latch u_req (
      .clk            (clk),
      .rst            (rst),
      .busy_i         (busy),
      .cplt_i         (cplt),
      .restart_i      (restart_i),
      .pend_rate_o    (pend_rate),
      .pend_restart_o (pend_restart)
   );

   txpa_interval_cnt #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .load_i     (cnt_load),
      .load_val_i (cnt_val),
      .zero_o     (cnt_zero)
   );

   // A rate request outranks a restart and absorbs it
   assign start_rate    = idle & (cplt | pend_rate);
   assign start_restart = idle & ~start_rate & (restart_i | pend_restart);
   assign finish        = (state_q == ST_WAITDONE) & reset_done_i;

   always_comb begin
      state_d  = state_q;
      kind_d   = kind_q;
      cnt_load = 1'b0;
      cnt_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_rate) begin
               state_d  = ST_CLKDIV;
               kind_d   = SEQ_RATE;
               cnt_load = 1'b1;
               cnt_val  = LD_CLKDIV;
            end else if (start_restart) begin
               state_d  = ST_ALIGN;
               kind_d   = SEQ_RESTART;
               cnt_load = 1'b1;
               cnt_val  = LD_ALIGN;
            end
         end
         ST_CLKDIV: begin
            if (cnt_zero) begin
               state_d  = ST_ALIGN;
               cnt_load = 1'b1;
               cnt_val  = LD_ALIGN;
            end
         end
         ST_ALIGN: begin
            if (cnt_zero) begin
               state_d  = ST_SETPH;
               cnt_load = 1'b1;
               cnt_val  = LD_SETPH;
            end
         end
         ST_SETPH: begin
            if (cnt_zero) begin
               state_d  = ST_TXRST;
               cnt_load = 1'b1;
               cnt_val  = LD_TXRST;
            end
         end
         ST_TXRST: begin
            if (cnt_zero) begin
               state_d = ST_WAITDONE;
            end
         end
         ST_WAITDONE: begin
            if (reset_done_i) begin
               state_d = ST_IDLE;
            end
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         kind_q  <= SEQ_RESTART;
      end else begin
         state_q <= state_d;
         kind_q  <= kind_d;
      end
   end

   // Transceiver status is masked from the first sign of a rate change
   // until the sequence and anything held behind it are done
   assign gate = armed | busy | pend_rate | pend_restart;

   txpa_stat_gate u_stat (
      .clk              (clk),
      .rst              (rst),
      .pcie_mode        (pcie_mode),
      .phystatus_i      (phystatus_i),
      .gate_i           (gate),
      .start_i          (start_rate | start_restart),
      .finish_i         (finish),
      .finish_rate_i    (kind_q == SEQ_RATE),
      .user_phystatus_o (user_phystatus_o),
      .sync_done_o      (sync_done_o)
   );

   assign clkdiv_rst_o = (state_q == ST_CLKDIV);
   assign align_en_o   = (state_q == ST_ALIGN) | (state_q == ST_SETPH) |
                         (state_q == ST_TXRST) | (state_q == ST_WAITDONE);
   assign set_phase_o  = (state_q == ST_SETPH);
   assign tx_rst_o     = (state_q == ST_TXRST);

endmodule

// File: rtl/txpa_seq_chk.sv
module txpa_seq_chk #(
   parameter int unsigned DIVRST_CYC     = 16,
   parameter int unsigned ALIGN_WAIT_CYC = 32,
   parameter int unsigned SETPH_CYC      = 8,
   parameter int unsigned TXRST_CYC      = 2
) (
   input logic clk,
   input logic rst,
   input logic pcie_mode,
   input logic rate_done_i,
   input logic phystatus_i,
   input logic restart_i,
   input logic reset_done_i,
   input logic clkdiv_rst_o,
   input logic align_en_o,
   input logic set_phase_o,
   input logic tx_rst_o,
   input logic user_phystatus_o,
   input logic sync_done_o
);

   int unsigned div_run;
   int unsigned align_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_run   <= 0;
         align_run <= 0;
      end else begin
         div_run   <= clkdiv_rst_o ? div_run + 1 : 0;
         align_run <= (align_en_o && !set_phase_o) ? align_run + 1 : 0;
      end
   end

   AST_CLKDIV_EXACT: assert property (@(posedge clk) disable iff (rst)
      $fell(clkdiv_rst_o) |-> (div_run == DIVRST_CYC));                          // R3

   AST_ALIGN_SETTLE: assert property (@(posedge clk) disable iff (rst)
      $rose(set_phase_o) |-> (align_run >= ALIGN_WAIT_CYC));                     // R4

   AST_STROBE_UNDER_EN: assert property (@(posedge clk) disable iff (rst)
      (set_phase_o || tx_rst_o) |-> align_en_o);                                 // R4

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({clkdiv_rst_o, set_phase_o, tx_rst_o}));                          // R5

   AST_EN_RELEASE: assert property (@(posedge clk) disable iff (rst)
      ($fell(align_en_o) && !$past(rst)) |-> $past(reset_done_i));               // R5

   AST_NO_PHYST_LEGACY: assert property (@(posedge clk) disable iff (rst)
      !pcie_mode |-> !user_phystatus_o);                                         // R7

   AST_NO_SYNC_PCIE: assert property (@(posedge clk) disable iff (rst)
      pcie_mode |-> !sync_done_o);                                               // R8

   AST_SYNC_LOW_RUNNING: assert property (@(posedge clk) disable iff (rst)
      align_en_o |-> !sync_done_o);                                              // R8

endmodule

bind txpa_seq txpa_seq_chk #(
   .DIVRST_CYC     (DIVRST_CYC),
   .ALIGN_WAIT_CYC (ALIGN_WAIT_CYC),
   .SETPH_CYC      (SETPH_CYC),
   .TXRST_CYC      (TXRST_CYC)
) u_chk (.*);

// File: tb/txpa_seq_bench.sv
`timescale 1ns/1ps
module txpa_seq_bench;

   localparam int DIV = 16;
   localparam int ALW = 32;
   localparam int SPH = 8;
   localparam int TXR = 2;
   localparam int RD_DLY = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic pcie_mode = 1'b0;
   logic rate_done_i = 1'b0;
   logic phystatus_i = 1'b0;
   logic restart_i = 1'b0;
   logic reset_done_i = 1'b1;
   logic clkdiv_rst_o, align_en_o, set_phase_o, tx_rst_o, user_phystatus_o, sync_done_o;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   // reference model state: phase 0 idle, 1 divider reset, 2 settle,
   // 3 set-phase, 4 tx reset, 5 wait for reset-done
   int m_ph = 0;
   int m_left = 0;
   bit m_armed = 0, m_prate = 0, m_prst = 0, m_krate = 0, m_sync = 0, m_rel = 0;

   bit rd_manual = 0;
   int rd_cnt = 0;
   int div_run = 0;
   int seq_cnt = 0;
   logic align_prev = 1'b0;

   always #2 clk = ~clk;

   txpa_seq #(.DIVRST_CYC(DIV), .ALIGN_WAIT_CYC(ALW), .SETPH_CYC(SPH), .TXRST_CYC(TXR)) u_txpa_seq (
      .clk(clk), .rst(rst), .pcie_mode(pcie_mode), .rate_done_i(rate_done_i),
      .phystatus_i(phystatus_i), .restart_i(restart_i), .reset_done_i(reset_done_i),
      .clkdiv_rst_o(clkdiv_rst_o), .align_en_o(align_en_o), .set_phase_o(set_phase_o),
      .tx_rst_o(tx_rst_o), .user_phystatus_o(user_phystatus_o), .sync_done_o(sync_done_o)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      bit cp;
      cp = 1'b0;
      if (rst) begin
         m_ph = 0; m_left = 0; m_armed = 0; m_prate = 0; m_prst = 0;
         m_krate = 0; m_sync = 0; m_rel = 0;
      end else begin
         cp = pcie_mode ? (m_armed && phystatus_i) : rate_done_i;
         if (!pcie_mode) m_armed = 0;
         else if (rate_done_i) m_armed = 1;
         else if (phystatus_i) m_armed = 0;
         m_rel = 0;
         if (m_ph == 0) begin
            if (cp || m_prate) begin
               m_ph = 1; m_left = DIV; m_krate = 1; m_sync = 0;
            end else if (restart_i || m_prst) begin
               m_ph = 2; m_left = ALW; m_krate = 0; m_sync = 0;
            end
            m_prate = 0; m_prst = 0;
         end else begin
            if (cp) m_prate = 1;
            if (restart_i) m_prst = 1;
            if (m_ph == 5) begin
               if (reset_done_i) begin
                  m_ph = 0; m_sync = 1; m_rel = m_krate && pcie_mode;
               end
            end else begin
               m_left--;
               if (m_left == 0) begin
                  m_ph++;
                  m_left = (m_ph == 2) ? ALW : (m_ph == 3) ? SPH : (m_ph == 4) ? TXR : 0;
               end
            end
         end
      end
   end

   // transceiver stand-in: reset-done drops on tx reset, returns later
   always @(negedge clk) begin
      if (!rd_manual) begin
         if (tx_rst_o) begin
            reset_done_i <= 1'b0;
            rd_cnt = RD_DLY;
         end else if (rd_cnt > 0) begin
            rd_cnt--;
            if (rd_cnt == 0) reset_done_i <= 1'b1;
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      bit gate;
      #1;
      gate = m_armed || (m_ph != 0) || m_prate || m_prst;
      chk(clkdiv_rst_o, m_ph == 1, "R3 clkdiv_rst_o");
      chk(align_en_o, m_ph >= 2, "R4 align_en_o");
      chk(set_phase_o, m_ph == 3, "R5 set_phase_o");
      chk(tx_rst_o, m_ph == 4, "R5 tx_rst_o");
      chk(user_phystatus_o, pcie_mode && (m_rel || (phystatus_i && !gate)), "R7 user_phystatus_o");
      chk(sync_done_o, !pcie_mode && m_sync, "R8 sync_done_o");
      if (clkdiv_rst_o) div_run++;
      else if (div_run > 0) begin
         chk_int(div_run, DIV, "R3 divider reset length");
         div_run = 0;
      end
      if (align_en_o && !align_prev) seq_cnt++;
      align_prev = align_en_o;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic pulse_rate();
      @(negedge clk); rate_done_i = 1'b1;
      @(negedge clk); rate_done_i = 1'b0; #1;
   endtask

   task automatic pulse_phy();
      @(negedge clk); phystatus_i = 1'b1;
      @(negedge clk); phystatus_i = 1'b0; #1;
   endtask

   task automatic pulse_restart();
      @(negedge clk); restart_i = 1'b1;
      @(negedge clk); restart_i = 1'b0; #1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); #1;
         if (m_ph == 0 && !m_prate && !m_prst) break;
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk); rst = 1'b1; pcie_mode = mode;
      @(negedge clk); rst = 1'b0; #1;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n0;
      // reset state
      cyc(3);
      chk(clkdiv_rst_o | align_en_o | set_phase_o | tx_rst_o, 1'b0, "R1 strobes low in reset");
      chk(sync_done_o | user_phystatus_o, 1'b0, "R1 status low in reset");
      @(negedge clk); rst = 1'b0;

      // legacy rate change
      pulse_rate();
      chk(clkdiv_rst_o, 1'b1, "R2 divider reset follows rate_done");
      wait_idle();
      chk(sync_done_o, 1'b1, "R8 sync_done after alignment");
      cyc(3);

      // legacy restart: no divider reset
      pulse_restart();
      chk(align_en_o, 1'b1, "R9 restart enters alignment");
      chk(clkdiv_rst_o, 1'b0, "R9 restart skips divider reset");
      chk(sync_done_o, 1'b0, "R8 sync_done cleared at start");
      wait_idle();
      cyc(2);

      // PCI Express mode
      do_reset(1'b1);
      @(negedge clk); phystatus_i = 1'b1; #1;
      chk(user_phystatus_o, 1'b1, "R7 idle status passes through");
      @(negedge clk); phystatus_i = 1'b0;
      cyc(3);
      chk(align_en_o | clkdiv_rst_o, 1'b0, "R6 lone status starts nothing");

      pulse_rate();
      cyc(2);
      chk(clkdiv_rst_o, 1'b0, "R6 rate_done alone insufficient");
      @(negedge clk); phystatus_i = 1'b1; #1;
      chk(user_phystatus_o, 1'b0, "R7 completing status masked");
      @(negedge clk); phystatus_i = 1'b0; #1;
      chk(clkdiv_rst_o, 1'b1, "R6 status after rate_done completes");
      cyc(30);
      pulse_phy();
      chk(user_phystatus_o, 1'b0, "R7 mid-sequence status masked");
      wait_idle();
      chk(user_phystatus_o, 1'b1, "R7 single release pulse");
      cyc(1);
      chk(user_phystatus_o, 1'b0, "R7 release pulse one cycle");

      // same-cycle rate_done and status: not a completion
      @(negedge clk); rate_done_i = 1'b1; phystatus_i = 1'b1;
      @(negedge clk); rate_done_i = 1'b0; phystatus_i = 1'b0;
      cyc(3);
      chk(clkdiv_rst_o, 1'b0, "R6 same-cycle status ignored");
      pulse_phy();
      chk(clkdiv_rst_o, 1'b1, "R6 later status completes");
      wait_idle();
      cyc(2);

      // restart in PCI Express mode: no release pulse; second restart held
      n0 = seq_cnt;
      pulse_restart();
      cyc(10);
      pulse_restart();
      wait_idle();
      cyc(2);
      chk_int(seq_cnt - n0, 2, "R10 held restart serviced");

      // legacy: completion in the same cycle as reset-done
      do_reset(1'b0);
      n0 = seq_cnt;
      rd_manual = 1;
      reset_done_i = 1'b0;
      pulse_rate();
      while (m_ph != 5) begin @(negedge clk); #1; end
      cyc(2);
      @(negedge clk); reset_done_i = 1'b1; rate_done_i = 1'b1;
      @(negedge clk); rate_done_i = 1'b0; #1;
      chk(clkdiv_rst_o, 1'b0, "R10 idle cycle between sequences");
      rd_manual = 0; rd_cnt = 0;
      cyc(1);
      chk(clkdiv_rst_o, 1'b1, "R10 coincident rate request serviced");
      wait_idle();
      cyc(2);
      chk_int(seq_cnt - n0, 2, "R10 two sequences run");

      // rate and restart together: one sequence
      n0 = seq_cnt;
      @(negedge clk); rate_done_i = 1'b1; restart_i = 1'b1;
      @(negedge clk); rate_done_i = 1'b0; restart_i = 1'b0;
      wait_idle();
      cyc(3);
      chk_int(seq_cnt - n0, 1, "R10 restart absorbed by rate sequence");

      // reset mid-sequence drops pending work
      pulse_rate();
      cyc(20);
      pulse_restart();
      do_reset(1'b0);
      chk(clkdiv_rst_o | align_en_o | set_phase_o | tx_rst_o, 1'b0, "R1 reset aborts sequence");
      cyc(5);
      chk(align_en_o, 1'b0, "R1 held request discarded");
      chk(sync_done_o, 1'b0, "R1 sync_done cleared");

      cyc(4);
      finish_run();
   end

endmodule